// File: doc/BRIEF.md
# Base Address Register Bank with Request Decoder

This block holds the base address registers of one device function together with the decoder that claims incoming requests for that function. Each register slot has a fixed region size and a fixed address space, either memory or I/O, chosen by parameters at build time. Firmware writes bases through a narrow write port and reads them back through a read port. A probe value of all ones, written and then read back, reveals the region size. A small command register holds one enable bit for each address space.

At run time each request carries an address and a space flag. The block compares the request against every programmed slot and reports a hit, the index of the winning slot, and whether more than one slot matched. Each slot runs a three-state machine. `SLOT_BLANK` is entered at reset. `SLOT_SIZING` is entered from any state by a write of all ones. `SLOT_LIVE` is entered from any state by a write of any other value. Only a slot in `SLOT_LIVE` may claim a request.

Top module: `bar_decoder`

## Requirements
- R1: After reset every slot reads back zero except bit 0, the command register (selector 6) reads 0, and no request hits.
- R2: Bit 0 of a slot reads 1 for an I/O slot and 0 for a memory slot, whatever value is written.
- R3: After a write of 32'hFFFF_FFFF to a slot, the slot reads back the complement of (size − 1) with bit 0 set to the slot's type. Memory slots are at least 16 bytes and I/O slots at least 4 bytes, so bits 3:1 of a memory slot always read zero.
- R4: Written bits below the region size are dropped. The slot reads back the written value with those bits cleared, then ORed with the type bit.
- R5: A slot in `SLOT_BLANK` or `SLOT_SIZING` never claims a request.
- R6: A live slot claims a request only if the request is valid, its space flag (1 = I/O) equals the slot's type, and the address bits at and above the size equal the stored base.
- R7: Command bit 0 enables I/O decoding and command bit 1 enables memory decoding. A cleared bit blocks every hit in that space. Only bits 1:0 are stored.
- R8: When several slots match, `hit_idx` gives the lowest index and `multi_hit` is 1. `multi_hit` is 0 whenever fewer than two slots match.
- R9: Without a hit, `hit` and `multi_hit` are 0 and `hit_idx` is 0.
- R10: Writes to selector 7 change nothing, and reading selector 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Write selector: 0..5 pick a slot, 6 picks the command register |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 3 | Read selector, same coding as the write selector |
| cfg_rd_data | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Request present |
| req_is_io | input | 1 | Request space: 1 = I/O, 0 = memory |
| req_addr | input | 32 | Request address |
| hit | output | 1 | Some slot claims the request |
| hit_idx | output | 3 | Index of the winning slot |
| multi_hit | output | 1 | More than one slot matched |

## Verification
A slot stuck in the wrong state, or holding a base masked with the wrong width, shows up on the ports in the first cycle after the write that caused it. The read path then returns a wrong value, and a decode at the region's first byte, last byte, or the bytes just outside it gives a wrong `hit`. Because decoding is combinational, any request placed on the inputs gives the verdict in that same cycle. The bench therefore probes region edges in both spaces under all four enable settings, and checks after every write.

// File: rtl/bar_pkg.sv
package bar_pkg;
    localparam int unsigned MAX_SLOTS = 6;
    localparam int unsigned SEL_W     = 3;
    localparam logic [SEL_W-1:0] CMD_SEL = 3'd6;
    localparam int unsigned CMD_IO_BIT  = 0;
    localparam int unsigned CMD_MEM_BIT = 1;

    typedef enum logic [1:0] {
        SLOT_BLANK,
        SLOT_SIZING,
        SLOT_LIVE
    } slot_state_e;
endpackage

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
#(
    parameter int unsigned SIZE_LOG2 = 12,
    parameter bit          IS_IO     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        space_en,
    input  logic        req_valid,
    input  logic        req_is_io,
    input  logic [31:0] req_addr,
    output logic [31:0] rd_val,
    output logic        match
);
    // Smallest legal region: 16 bytes for memory, 4 bytes for I/O.
    localparam int unsigned MIN_LOG2 = IS_IO ? 2 : 4;
    localparam int unsigned EFF_LOG2 = (SIZE_LOG2 < MIN_LOG2) ? MIN_LOG2 : SIZE_LOG2;
    localparam logic [31:0] LOW_MASK  = (32'd1 << EFF_LOG2) - 32'd1;
    localparam logic [31:0] BASE_MASK = ~LOW_MASK;

    slot_state_e state_q, state_d;
    logic [31:0] base_q;
    logic        live;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wr_data == 32'hFFFF_FFFF) state_d = SLOT_SIZING;
            else                          state_d = SLOT_LIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_BLANK;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en) base_q <= wr_data & BASE_MASK;
        end
    end

    always_comb begin
        unique case (state_q)
            SLOT_BLANK:  live = 1'b0;
            SLOT_SIZING: live = 1'b0;
            SLOT_LIVE:   live = 1'b1;
            default:     live = 1'b0;
        endcase
    end

    assign rd_val = base_q | {31'd0, IS_IO};
    assign match  = live && req_valid && space_en && (req_is_io == IS_IO)
                    && ((req_addr & BASE_MASK) == base_q);

    // R3
    probe_enters_sizing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 32'hFFFF_FFFF) |=> (state_q == SLOT_SIZING));

    // R4
    write_drops_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != 32'hFFFF_FFFF) |=>
            (state_q == SLOT_LIVE && rd_val == (($past(wr_data) & BASE_MASK) | {31'd0, IS_IO})));

    // R5
    idle_slot_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SLOT_LIVE) |-> !match);
endmodule

// File: rtl/hit_picker.sv
module hit_picker
    import bar_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0]     match_vec,
    output logic             hit,
    output logic [SEL_W-1:0] hit_idx,
    output logic             multi_hit
);
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (match_vec[k]) begin
                hit     = 1'b1;
                hit_idx = SEL_W'(k);
            end
        end
    end

    assign multi_hit = (match_vec & (match_vec - 1'b1)) != '0;

    // R8
    always_comb begin
        if (hit) begin
            lowest_wins_chk: assert ((match_vec & ((N'(1) << hit_idx) - N'(1))) == '0 && match_vec[hit_idx]);
        end
    end
endmodule

// File: rtl/bar_decoder.sv
module bar_decoder
    import bar_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6,
    parameter int unsigned BAR_SIZE_LOG2 [MAX_SLOTS] = '{12, 4, 16, 8, 4, 20},
    parameter logic [MAX_SLOTS-1:0] BAR_IS_IO = 6'b001010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_wr_sel,
    input  logic [31:0] cfg_wr_data,
    input  logic [2:0]  cfg_rd_sel,
    output logic [31:0] cfg_rd_data,
    input  logic        req_valid,
    input  logic        req_is_io,
    input  logic [31:0] req_addr,
    output logic        hit,
    output logic [2:0]  hit_idx,
    output logic        multi_hit
);
    logic [1:0]          cmd_q;
    logic [31:0]         rd_vals [NUM_BARS];
    logic [NUM_BARS-1:0] match_vec;

    always_ff @(posedge clk) begin
        if (!rst_n)                                  cmd_q <= 2'b00;
        else if (cfg_wr_en && cfg_wr_sel == CMD_SEL) cmd_q <= cfg_wr_data[1:0];
    end

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
        logic slot_en;
        assign slot_en = BAR_IS_IO[g] ? cmd_q[CMD_IO_BIT] : cmd_q[CMD_MEM_BIT];
        bar_slot #(
            .SIZE_LOG2 (BAR_SIZE_LOG2[g]),
            .IS_IO     (BAR_IS_IO[g])
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_wr_en && cfg_wr_sel == SEL_W'(g)),
            .wr_data   (cfg_wr_data),
            .space_en  (slot_en),
            .req_valid (req_valid),
            .req_is_io (req_is_io),
            .req_addr  (req_addr),
            .rd_val    (rd_vals[g]),
            .match     (match_vec[g])
        );
    end

    always_comb begin
        cfg_rd_data = '0;
        if (cfg_rd_sel < SEL_W'(NUM_BARS))  cfg_rd_data = rd_vals[cfg_rd_sel];
        else if (cfg_rd_sel == CMD_SEL)     cfg_rd_data = {30'd0, cmd_q};
    end

    hit_picker #(.N(NUM_BARS)) u_pick (
        .match_vec (match_vec),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .multi_hit (multi_hit)
    );

    // R6
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> req_valid);

    // R7
    hit_needs_space_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req_is_io ? cmd_q[CMD_IO_BIT] : cmd_q[CMD_MEM_BIT]));

    // R8
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit);

    // R9
    idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == 3'd0 && !multi_hit));
endmodule

// File: tb/sim_bar_decoder.sv
module sim_bar_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_sel = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit;
    logic [2:0]  hit_idx;
    logic        multi_hit;

    int errors = 0;
    int checks = 0;

    int unsigned sz_m [6]   = '{12, 4, 16, 8, 4, 20};
    bit          io_m [6]   = '{0, 1, 0, 1, 0, 0};
    logic [31:0] base_m [6] = '{32'h4000_0000, 32'h0000_1000, 32'h5000_0000,
                                32'h0000_2000, 32'h4000_0010, 32'h6000_0000};
    logic [31:0] held_m [6];
    bit          live_m [6];
    bit          io_en_m = 0;
    bit          mem_en_m = 0;

    always #4 clk = ~clk;

    bar_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
        .hit(hit), .hit_idx(hit_idx), .multi_hit(multi_hit)
    );

    function automatic logic [31:0] low_mask(int i);
        return (32'd1 << sz_m[i]) - 32'd1;
    endfunction

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic check_read(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_rd_sel = sel;
        #1;
        checks++;
        if (cfg_rd_data !== exp) begin
            errors++;
            $display("FAIL %s read sel %0d: actual %h expected %h", tag, sel, cfg_rd_data, exp);
        end
    endtask

    task automatic check_dec(input bit v, input bit isio, input logic [31:0] addr, input string tag);
        bit e_hit; bit e_multi; logic [2:0] e_idx; int n;
        e_hit = 0; e_multi = 0; e_idx = 0; n = 0;
        for (int j = 0; j < 6; j++) begin
            if (v && live_m[j] && io_m[j] == isio && (isio ? io_en_m : mem_en_m)
                && ((addr & ~low_mask(j)) == held_m[j])) begin
                if (n == 0) e_idx = 3'(j);
                n++;
            end
        end
        e_hit = (n > 0); e_multi = (n > 1);
        @(negedge clk);
        req_valid = v; req_is_io = isio; req_addr = addr;
        #1;
        checks++;
        if (hit !== e_hit || hit_idx !== e_idx || multi_hit !== e_multi) begin
            errors++;
            $display("FAIL %s dec v=%0d io=%0d addr=%h: actual hit=%0d idx=%0d multi=%0d expected hit=%0d idx=%0d multi=%0d",
                     tag, v, isio, addr, hit, hit_idx, multi_hit, e_hit, e_idx, e_multi);
        end
        req_valid = 1'b0;
    endtask

    task automatic set_cmd(input bit ioe, input bit meme);
        cfg_write(3'd6, {30'h3FFF_FFFF, meme, ioe});
        io_en_m = ioe; mem_en_m = meme;
        check_read(3'd6, {30'd0, meme, ioe}, "R7");
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin live_m[i] = 0; held_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 6; i++) check_read(3'(i), {31'd0, io_m[i]}, "R1");
        check_read(3'd6, 32'd0, "R1");
        check_dec(1, 0, 32'h0, "R1");
        check_dec(1, 1, 32'h0, "R1");

        // R7: enables on; blank slots with base 0 still silent (R5)
        set_cmd(1, 1);
        check_dec(1, 0, 32'h0, "R5");
        check_dec(1, 1, 32'h0, "R5");

        // R2: type bit is read-only
        cfg_write(3'd1, 32'h0000_0000);
        live_m[1] = 1; held_m[1] = 32'h0;
        check_read(3'd1, 32'h0000_0001, "R2");
        cfg_write(3'd0, 32'h4000_0001);
        live_m[0] = 1; held_m[0] = 32'h4000_0000;
        check_read(3'd0, 32'h4000_0000, "R2");

        // R3: sizing probe on every slot, then no slot answers (R5)
        for (int i = 0; i < 6; i++) begin
            cfg_write(3'(i), 32'hFFFF_FFFF);
            live_m[i] = 0; held_m[i] = ~low_mask(i);
            check_read(3'(i), ~low_mask(i) | {31'd0, io_m[i]}, "R3");
        end
        check_dec(1, 0, 32'hFFFF_FFF0, "R5");
        check_dec(1, 1, 32'hFFFF_FFFC, "R5");

        // R4: program bases with garbage below the size
        for (int i = 0; i < 6; i++) begin
            cfg_write(3'(i), base_m[i] | (low_mask(i) & 32'h5A5A_5A5B));
            live_m[i] = 1; held_m[i] = base_m[i];
            check_read(3'(i), base_m[i] | {31'd0, io_m[i]}, "R4");
        end

        // R10: selector 7 inert
        cfg_write(3'd7, 32'h1234_5678);
        check_read(3'd7, 32'd0, "R10");
        for (int i = 0; i < 6; i++) check_read(3'(i), base_m[i] | {31'd0, io_m[i]}, "R10");
        check_read(3'd6, 32'd3, "R10");

        // R8: overlap of slot 0 and slot 4
        check_dec(1, 0, 32'h4000_0010, "R8");
        check_dec(1, 0, 32'h4000_001F, "R8");
        check_dec(1, 0, 32'h4000_0020, "R8");

        // R6/R7/R9: region edges in both spaces under every enable setting
        for (int en = 0; en < 4; en++) begin
            set_cmd(en[0], en[1]);
            for (int i = 0; i < 6; i++) begin
                for (int s = 0; s < 2; s++) begin
                    check_dec(1, s[0], base_m[i],                "R6");
                    check_dec(1, s[0], base_m[i] + low_mask(i),  "R6");
                    check_dec(1, s[0], base_m[i] + low_mask(i) + 32'd1, "R6");
                    check_dec(1, s[0], base_m[i] - 32'd1,        "R6");
                end
                check_dec(0, io_m[i], base_m[i], "R9");
            end
        end

        // R5: re-probing a slot takes it off the bus
        cfg_write(3'd2, 32'hFFFF_FFFF);
        live_m[2] = 0; held_m[2] = ~low_mask(2);
        check_dec(1, 0, 32'h5000_0000, "R5");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule